// File: doc/BRIEF.md
# I2C Master Buffered Command Sequencer

This block is the per-bus command engine of an I2C master. Software writes a command word, and the sequencer runs up to four bus steps in a fixed order: a start condition carrying the address byte, a transmit step, a receive step (optionally closed with a NAK), and a stop condition. Each data step works in one of two ways. In single-byte mode it uses one byte register. In buffered mode it uses a window of a local byte RAM, whose base is set by a pool control register.

The sequencer never touches SCL or SDA. For each step it posts a byte-level operation to a separate bit-level engine and holds that operation until the engine answers with a done pulse. A send or start operation also returns an ACK or NAK flag. Results are recorded as sticky interrupt status bits, which software clears by writing ones. A level interrupt output is driven from the status bits that are enabled.

In buffered transmit, the address byte is taken from slot 0 of the window. When the transmit count is one, the transmit step is dropped. When the count is larger, transmission resumes at slot 1. A buffered receive fills the window from slot 0 and reports the number of bytes received in the top byte of pool control.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the block is idle: busy, irq and eng_req are low, and the command, pool control, byte data, status and enable registers all read 0.
- R2: The command register (word 0) stores only bits 15:0 of a write. Its step bits are bit0 start, bit1 transmit, bit3 receive and bit5 stop. The steps run in the order start, transmit, receive, stop. Steps whose bits are clear are skipped. busy stays high from the cycle after the write until the whole sequence has ended.
- R3: The start operation carries the address byte. In buffered-transmit mode (command bit6) this is buffer slot 0 of the window, at byte address 4 × pool bits 5:0. Otherwise it is byte data bits 7:0. An ACK sets status bit0 and a NAK sets status bit1.
- R4: After a start, single-byte transmit is dropped. Buffered transmit with a count of 1 (pool bits 15:8 = 0) is also dropped. A larger count resumes at slot 1. A buffered transmit without a start sends slots 0 up to count − 1. Each buffered transmit that completes sets status bit0.
- R5: A NAK on a send ends the transmit step at once. It sets status bit1, abandons the remaining steps, issues a stop, and clears command bits 1, 3, 4, 6 and 7.
- R6: Buffered receive (command bit7) fills slots 0 to size − 1, where size is pool bits 23:16 plus 1. It then writes the byte count into pool bits 31:24, clears bit7 and sets status bit2. A single-byte receive places the byte in byte data bits 15:8 and also sets status bit2.
- R7: When command bit4 is set, a NAK operation follows the final received byte.
- R8: If the start is answered with a NAK, the remaining steps are abandoned and only a stop follows.
- R9: A pool control write (word 1) updates bits 23:0 only. Bits 31:24 keep the last receive count.
- R10: Interrupt status (word 3) is sticky: bit0 transmit ACK, bit1 transmit NAK, bit2 receive done, bit3 stop done. Writing a one to a bit clears it. irq is high exactly when a status bit and its enable bit (word 4) are both set.
- R11: While busy, writes to the command, pool control and byte data registers (word 2) have no effect, and neither do software writes to the buffer.
- R12: Engine operations are coded 1 start, 2 send, 3 receive, 4 NAK, 5 stop. eng_req stays high with a stable eng_op until eng_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| buf_wr | input | 1 | Software buffer write strobe |
| buf_addr | input | BUF_AW | Software buffer byte address |
| buf_wdata | input | 8 | Software buffer write data |
| buf_rdata | output | 8 | Buffer byte at buf_addr |
| eng_req | output | 1 | Operation request to the bit engine |
| eng_op | output | 3 | Operation code |
| eng_wdata | output | 8 | Byte for a start or send operation |
| eng_done | input | 1 | One-cycle completion of the current operation |
| eng_nak | input | 1 | NAK result, valid with eng_done |
| eng_rdata | input | 8 | Received byte, valid with eng_done |
| busy | output | 1 | A command sequence is running |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a NAK that arrives in the middle of a buffered transmit. By then the start has been acknowledged and some slots have already gone out, yet a stop must still follow. The bench's engine model can be told to NAK exactly the n-th send of a run, and it can also NAK the start. The full operation sequence is then compared against the expected order. Writes issued while a long buffered receive is in progress confirm that the register, buffer and command state are frozen.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_SEND  = 3'd2,
        OP_RECV  = 3'd3,
        OP_NAK   = 3'd4,
        OP_STOP  = 3'd5
    } eng_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_TX, ST_RX, ST_NAK, ST_STOP
    } seq_st_e;

    localparam int CB_START = 0;
    localparam int CB_TX    = 1;
    localparam int CB_RX    = 3;
    localparam int CB_LAST  = 4;
    localparam int CB_STOP  = 5;
    localparam int CB_TXBUF = 6;
    localparam int CB_RXBUF = 7;

    localparam int IS_TXACK  = 0;
    localparam int IS_TXNAK  = 1;
    localparam int IS_RXDONE = 2;
    localparam int IS_STOP   = 3;
    localparam int IS_W      = 4;

    localparam logic [2:0] RA_CMD  = 3'd0;
    localparam logic [2:0] RA_POOL = 3'd1;
    localparam logic [2:0] RA_BYTE = 3'd2;
    localparam logic [2:0] RA_ISTS = 3'd3;
    localparam logic [2:0] RA_IEN  = 3'd4;

    typedef struct packed {
        logic [7:0] rx_cnt;
        logic [7:0] rx_szm1;
        logic [7:0] tx_cntm1;
        logic [1:0] rsvd;
        logic [5:0] offset;
    } pool_t;

    function automatic seq_st_e first_step(input logic st, input logic tx,
                                           input logic rx, input logic sp);
        if (st)      return ST_START;
        else if (tx) return ST_TX;
        else if (rx) return ST_RX;
        else if (sp) return ST_STOP;
        else         return ST_IDLE;
    endfunction

    function automatic eng_op_e op_of(input seq_st_e s);
        case (s)
            ST_START: return OP_START;
            ST_TX:    return OP_SEND;
            ST_RX:    return OP_RECV;
            ST_NAK:   return OP_NAK;
            ST_STOP:  return OP_STOP;
            default:  return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/i2c_seq_buf.sv
module i2c_seq_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [7:0]    sw_wdata,
    output logic [7:0]    sw_rdata,
    input  logic          sq_we,
    input  logic [AW-1:0] sq_addr,
    input  logic [7:0]    sq_wdata,
    output logic [7:0]    sq_rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (sq_we)      mem[sq_addr] <= sq_wdata;
        else if (sw_we) mem[sw_addr] <= sw_wdata;
    end

    assign sw_rdata = mem[sw_addr];
    assign sq_rdata = mem[sq_addr];

    AST_BUF_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(sq_we && sw_we)); // R11
endmodule

// File: rtl/i2c_seq_irq.sv
module i2c_seq_irq #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         wr_sts,
    input  logic         wr_ien,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sts,
    output logic [W-1:0] ien,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            ien <= '0;
        end else begin
            sts <= (sts & ~(wr_sts ? wdata : '0)) | set;
            if (wr_ien) ien <= wdata;
        end
    end

    assign irq = |(sts & ien);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && set == '0) |=> (sts & $past(wdata)) == '0); // R10
    AST_SET_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> (sts & $past(set)) == $past(set)); // R10
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [31:0]   wr_data,
    output logic [15:0]   cmd_q,
    output logic [31:0]   pool_q,
    output logic [15:0]   byte_q,
    output logic          busy,
    output logic          eng_req,
    output logic [2:0]    eng_op,
    output logic [7:0]    eng_wdata,
    input  logic          eng_done,
    input  logic          eng_nak,
    input  logic [7:0]    eng_rdata,
    output logic [AW-1:0] buf_addr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    input  logic [7:0]    buf_rdata,
    output logic [IS_W-1:0] sts_set
);
    seq_st_e    st;
    logic [15:0] cmd;
    pool_t      pool;
    logic [15:0] bdat;
    logic [8:0] idx;

    logic       tx_buf, rx_buf, tx_last, rx_last;
    logic [8:0] tx_total, rx_total;

    assign tx_buf   = cmd[CB_TXBUF];
    assign rx_buf   = cmd[CB_RXBUF];
    assign tx_total = {1'b0, pool.tx_cntm1} + 9'd1;
    assign rx_total = {1'b0, pool.rx_szm1} + 9'd1;
    assign tx_last  = (idx + 9'd1) == tx_total;
    assign rx_last  = (idx + 9'd1) == rx_total;

    assign buf_addr  = AW'({pool.offset, 2'b00}) + AW'(idx);
    assign buf_we    = (st == ST_RX) && eng_done && rx_buf;
    assign buf_wdata = eng_rdata;

    assign busy      = (st != ST_IDLE);
    assign eng_req   = busy;
    assign eng_op    = op_of(st);
    assign eng_wdata = (st == ST_START || st == ST_TX) ?
                       (tx_buf ? buf_rdata : bdat[7:0]) : 8'h00;

    assign cmd_q  = cmd;
    assign pool_q = pool;
    assign byte_q = bdat;

    always_comb begin
        sts_set = '0;
        if (eng_done) begin
            case (st)
                ST_START: begin
                    sts_set[IS_TXNAK] = eng_nak;
                    sts_set[IS_TXACK] = !eng_nak;
                end
                ST_TX: begin
                    sts_set[IS_TXNAK] = eng_nak;
                    sts_set[IS_TXACK] = !eng_nak && (!tx_buf || tx_last);
                end
                ST_RX:   sts_set[IS_RXDONE] = !rx_buf || rx_last;
                ST_STOP: sts_set[IS_STOP] = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cmd  <= '0;
            pool <= '0;
            bdat <= '0;
            idx  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (wr_en) begin
                    case (wr_addr)
                        RA_CMD: begin
                            cmd <= wr_data[15:0];
                            idx <= '0;
                            st  <= first_step(wr_data[CB_START], wr_data[CB_TX],
                                              wr_data[CB_RX], wr_data[CB_STOP]);
                        end
                        RA_POOL: pool <= pool_t'({pool.rx_cnt, wr_data[23:0]});
                        RA_BYTE: bdat <= {8'h00, wr_data[7:0]};
                        default: ;
                    endcase
                end
                ST_START: if (eng_done) begin
                    cmd[CB_START] <= 1'b0;
                    if (eng_nak) begin
                        cmd[CB_TX]    <= 1'b0;
                        cmd[CB_RX]    <= 1'b0;
                        cmd[CB_LAST]  <= 1'b0;
                        cmd[CB_TXBUF] <= 1'b0;
                        cmd[CB_RXBUF] <= 1'b0;
                        st <= ST_STOP;
                    end else if (tx_buf && tx_total != 9'd1 && cmd[CB_TX]) begin
                        idx <= 9'd1;
                        st  <= ST_TX;
                    end else begin
                        cmd[CB_TX] <= 1'b0;
                        if (tx_buf) cmd[CB_TXBUF] <= 1'b0;
                        st <= first_step(1'b0, 1'b0, cmd[CB_RX], cmd[CB_STOP]);
                    end
                end
                ST_TX: if (eng_done) begin
                    if (eng_nak) begin
                        cmd[CB_TX]    <= 1'b0;
                        cmd[CB_RX]    <= 1'b0;
                        cmd[CB_LAST]  <= 1'b0;
                        cmd[CB_TXBUF] <= 1'b0;
                        cmd[CB_RXBUF] <= 1'b0;
                        idx <= '0;
                        st  <= ST_STOP;
                    end else if (tx_buf && !tx_last) begin
                        idx <= idx + 9'd1;
                    end else begin
                        cmd[CB_TX]    <= 1'b0;
                        cmd[CB_TXBUF] <= 1'b0;
                        idx <= '0;
                        st  <= first_step(1'b0, 1'b0, cmd[CB_RX], cmd[CB_STOP]);
                    end
                end
                ST_RX: if (eng_done) begin
                    if (rx_buf && !rx_last) begin
                        idx <= idx + 9'd1;
                    end else begin
                        if (rx_buf) begin
                            pool.rx_cnt   <= rx_total[7:0];
                            cmd[CB_RXBUF] <= 1'b0;
                        end else begin
                            bdat[15:8] <= eng_rdata;
                        end
                        idx <= '0;
                        if (cmd[CB_LAST]) begin
                            st <= ST_NAK;
                        end else begin
                            cmd[CB_RX] <= 1'b0;
                            st <= first_step(1'b0, 1'b0, 1'b0, cmd[CB_STOP]);
                        end
                    end
                end
                ST_NAK: if (eng_done) begin
                    cmd[CB_RX]   <= 1'b0;
                    cmd[CB_LAST] <= 1'b0;
                    st <= first_step(1'b0, 1'b0, 1'b0, cmd[CB_STOP]);
                end
                ST_STOP: if (eng_done) begin
                    cmd[CB_STOP] <= 1'b0;
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op))); // R12
    AST_TX_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX && tx_buf) |-> (idx < tx_total)); // R4
    AST_RX_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RX && rx_buf) |-> (idx < rx_total)); // R6
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP && eng_done) |=> !busy); // R2
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_seq_pkg::*;
#(
    parameter int BUF_DEPTH = 256,
    parameter int BUF_AW    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              buf_wr,
    input  logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic [7:0]        buf_rdata,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic [7:0]        eng_wdata,
    input  logic              eng_done,
    input  logic              eng_nak,
    input  logic [7:0]        eng_rdata,
    output logic              busy,
    output logic              irq
);
    logic [15:0]     cmd_q, byte_q;
    logic [31:0]     pool_q;
    logic [IS_W-1:0] sts_set, sts, ien;
    logic [BUF_AW-1:0] sq_addr;
    logic            sq_we;
    logic [7:0]      sq_wdata, sq_rdata;

    i2c_seq_fsm #(.AW(BUF_AW)) u_fsm (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .cmd_q(cmd_q), .pool_q(pool_q), .byte_q(byte_q), .busy(busy),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_done(eng_done), .eng_nak(eng_nak), .eng_rdata(eng_rdata),
        .buf_addr(sq_addr), .buf_we(sq_we), .buf_wdata(sq_wdata),
        .buf_rdata(sq_rdata), .sts_set(sts_set)
    );

    i2c_seq_buf #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_buf (
        .clk(clk), .rst(rst),
        .sw_we(buf_wr && !busy), .sw_addr(buf_addr), .sw_wdata(buf_wdata),
        .sw_rdata(buf_rdata),
        .sq_we(sq_we), .sq_addr(sq_addr), .sq_wdata(sq_wdata),
        .sq_rdata(sq_rdata)
    );

    i2c_seq_irq #(.W(IS_W)) u_irq (
        .clk(clk), .rst(rst), .set(sts_set),
        .wr_sts(reg_wr && reg_addr == RA_ISTS),
        .wr_ien(reg_wr && reg_addr == RA_IEN),
        .wdata(reg_wdata[IS_W-1:0]),
        .sts(sts), .ien(ien), .irq(irq)
    );

    always_comb begin
        case (reg_addr)
            RA_CMD:  reg_rdata = {16'h0000, cmd_q};
            RA_POOL: reg_rdata = pool_q;
            RA_BYTE: reg_rdata = {16'h0000, byte_q};
            RA_ISTS: reg_rdata = 32'(sts);
            RA_IEN:  reg_rdata = 32'(ien);
            default: reg_rdata = 32'h0;
        endcase
    end
endmodule

// File: tb/i2c_cmd_seq_tb.sv
module i2c_cmd_seq_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        buf_wr = 1'b0;
    logic [7:0]  buf_addr = 8'h0;
    logic [7:0]  buf_wdata = 8'h0;
    logic [7:0]  buf_rdata;
    logic        eng_req;
    logic [2:0]  eng_op;
    logic [7:0]  eng_wdata;
    logic        eng_done = 1'b0;
    logic        eng_nak = 1'b0;
    logic [7:0]  eng_rdata = 8'h0;
    logic        busy, irq;

    i2c_cmd_seq u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_wr(buf_wr),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_done(eng_done), .eng_nak(eng_nak), .eng_rdata(eng_rdata),
        .busy(busy), .irq(irq)
    );

    int tests = 0;
    int fails = 0;

    // bit-engine model
    logic       cfg_start_nak = 1'b0;
    int         cfg_nak_abs = 0;
    int         send_total = 0;
    int         recv_total = 0;
    int         log_n = 0;
    int         hold_err = 0;
    int         wcnt = 0;
    logic [2:0] log_op [512];
    logic [7:0] log_dat [512];
    logic       prev_open = 1'b0;
    logic [2:0] prev_op = 3'd0;

    always @(posedge clk) begin
        prev_open <= eng_req && !eng_done;
        prev_op   <= eng_op;
        if (eng_req && prev_open && eng_op != prev_op) hold_err <= hold_err + 1;
        if (eng_done) begin
            eng_done <= 1'b0;
            eng_nak  <= 1'b0;
            wcnt     <= 0;
        end else if (eng_req) begin
            if (wcnt == 2) begin
                eng_done <= 1'b1;
                log_op[log_n[8:0]]  <= eng_op;
                log_dat[log_n[8:0]] <= eng_wdata;
                log_n <= log_n + 1;
                eng_nak <= 1'b0;
                if (eng_op == 3'd1) eng_nak <= cfg_start_nak;
                if (eng_op == 3'd2) begin
                    eng_nak <= (send_total + 1 == cfg_nak_abs);
                    send_total <= send_total + 1;
                end
                if (eng_op == 3'd3) begin
                    eng_rdata  <= 8'hC0 + 8'(recv_total);
                    recv_total <= recv_total + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic buf_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        buf_wr = 1'b1; buf_addr = a; buf_wdata = d;
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic buf_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = a;
        #1 d = buf_rdata;
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 2000, "R2 sequence end", 32'(guard), 32'd0);
    endtask

    task automatic run_cmd(input logic [15:0] c, input logic [23:0] p,
                           input logic sn, input int na, output int base);
        reg_write(3'd3, 32'hF);
        reg_write(3'd1, {8'h00, p});
        cfg_start_nak = sn;
        cfg_nak_abs = (na == 0) ? 0 : send_total + na;
        base = log_n;
        reg_write(3'd0, {16'h0000, c});
        wait_idle();
    endtask

    function automatic logic [31:0] ops_since(input int base);
        logic [31:0] r = '0;
        for (int k = base; k < log_n && k < base + 8; k++)
            r |= 32'(log_op[k[8:0]]) << (4 * (k - base));
        return r;
    endfunction

    typedef struct packed {
        logic [15:0] cmd;
        logic [23:0] pool;
        logic        start_nak;
        logic [3:0]  nak_at;
        logic [31:0] ops;
        logic [3:0]  sts;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{16'h0021, 24'h000000, 1'b0, 4'd0, 32'h00000051, 4'h9}, // R2 start+stop
        '{16'h0023, 24'h000000, 1'b0, 4'd0, 32'h00000051, 4'h9}, // R4 byte tx dropped
        '{16'h0063, 24'h000200, 1'b0, 4'd0, 32'h00005221, 4'h9}, // R4 count 3
        '{16'h0063, 24'h000000, 1'b0, 4'd0, 32'h00000051, 4'h9}, // R4 count 1
        '{16'h00A9, 24'h020000, 1'b0, 4'd0, 32'h00053331, 4'hD}, // R6 buffered rx
        '{16'h0039, 24'h000000, 1'b0, 4'd0, 32'h00005431, 4'hD}, // R7 last nak
        '{16'h002B, 24'h000000, 1'b1, 4'd0, 32'h00000051, 4'hA}, // R8 no slave
        '{16'h0063, 24'h000300, 1'b0, 4'd2, 32'h00005221, 4'hB}, // R5 tx nak
        '{16'h00FB, 24'h010100, 1'b0, 4'd0, 32'h00543321, 4'hD}, // R2 full order
        '{16'h0008, 24'h000000, 1'b0, 4'd0, 32'h00000003, 4'h4}, // R2 rx only
        '{16'h0042, 24'h000100, 1'b0, 4'd0, 32'h00000022, 4'h1}  // R4 tx from slot 0
    };

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        int          base;
        int          r0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !irq && !eng_req, "R1 idle outputs",
              {29'h0, busy, irq, eng_req}, 32'h0);
        for (int a = 0; a < 5; a++) begin
            reg_read(3'(a), v);
            check(v == 32'h0, "R1 register reset", v, 32'h0);
        end

        for (int i = 0; i < 32; i++) buf_write(8'(i), 8'h10 + 8'(i));
        reg_write(3'd2, 32'h55);

        // table of sequences
        for (int i = 0; i < 11; i++) begin
            run_cmd(VECS[i].cmd, VECS[i].pool, VECS[i].start_nak,
                    int'(VECS[i].nak_at), base);
            check(ops_since(base) == VECS[i].ops && (log_n - base) <= 8,
                  "R2/R4/R5/R6/R7/R8 op order", ops_since(base), VECS[i].ops);
            reg_read(3'd3, v);
            check(v == 32'(VECS[i].sts), "R3/R5/R6/R10 status", v, 32'(VECS[i].sts));
        end
        cfg_start_nak = 1'b0;

        // R2 only low half of a command write is stored
        reg_write(3'd0, 32'hFFFF_0000);
        reg_read(3'd0, v);
        check(v == 32'h0 && !busy, "R2 upper command bits dropped", v, 32'h0);

        // R3 address source
        run_cmd(16'h0021, 24'h000000, 1'b0, 0, base);
        check(log_dat[base[8:0]] == 8'h55, "R3 byte-mode address",
              32'(log_dat[base[8:0]]), 32'h55);
        run_cmd(16'h0063, 24'h000101, 1'b0, 0, base);
        check(log_dat[base[8:0]] == 8'h14 && log_dat[9'(base + 1)] == 8'h15,
              "R3 buffered address slot 0 at offset",
              {16'h0, log_dat[base[8:0]], log_dat[9'(base + 1)]}, 32'h1415);

        // R6 buffered receive contents and count
        r0 = recv_total;
        run_cmd(16'h00A9, 24'h020002, 1'b0, 0, base);
        for (int k = 0; k < 3; k++) begin
            buf_read(8'(8 + k), b);
            check(b == 8'hC0 + 8'(r0 + k), "R6 buffer fill", 32'(b), 32'(8'hC0 + 8'(r0 + k)));
        end
        reg_read(3'd1, v);
        check(v[31:24] == 8'd3, "R6 receive count", 32'(v[31:24]), 32'd3);
        reg_read(3'd0, v);
        check(v[7] == 1'b0, "R6 rx buffer enable cleared", v, 32'h0);
        r0 = recv_total;
        run_cmd(16'h0008, 24'h000000, 1'b0, 0, base);
        reg_read(3'd2, v);
        check(v[15:8] == 8'hC0 + 8'(r0), "R6 byte receive", 32'(v[15:8]), 32'(8'hC0 + 8'(r0)));

        // R9 count field is read-only
        reg_write(3'd1, 32'hFFFF_FFFF);
        reg_read(3'd1, v);
        check(v == 32'h03FF_FFFF, "R9 pool write mask", v, 32'h03FF_FFFF);

        // R11 writes while busy are ignored
        reg_write(3'd2, 32'h55);
        reg_write(3'd1, 32'h0007_0000);
        base = log_n;
        reg_write(3'd0, 32'h88);
        reg_write(3'd2, 32'h77);
        reg_write(3'd1, 32'h0);
        buf_write(8'd20, 8'hEE);
        reg_write(3'd0, 32'h21);
        check(busy == 1'b1, "R11 writes landed while busy", 32'(busy), 32'h1);
        wait_idle();
        reg_read(3'd2, v);
        check(v[7:0] == 8'h55, "R11 byte data frozen", v, 32'h55);
        reg_read(3'd1, v);
        check(v[23:0] == 24'h070000, "R11 pool frozen", v, 32'h00070000);
        buf_read(8'd20, b);
        check(b == 8'h24, "R11 buffer frozen", 32'(b), 32'h24);
        check(log_n - base == 8, "R11 command ignored", 32'(log_n - base), 32'd8);

        // R10 interrupt gating and write-one-to-clear
        reg_write(3'd1, 32'h0);
        run_cmd(16'h0021, 24'h000000, 1'b0, 0, base);
        reg_write(3'd4, 32'h0);
        @(negedge clk);
        check(irq == 1'b0, "R10 irq masked", 32'(irq), 32'h0);
        reg_write(3'd4, 32'h8);
        @(negedge clk);
        check(irq == 1'b1, "R10 irq enabled", 32'(irq), 32'h1);
        reg_write(3'd3, 32'h8);
        reg_read(3'd3, v);
        check(v == 32'h1 && !irq, "R10 write one clears", v, 32'h1);
        reg_write(3'd3, 32'h1);
        reg_read(3'd3, v);
        check(v == 32'h0, "R10 status empty", v, 32'h0);

        // R12 handshake held
        check(hold_err == 0, "R12 request hold", 32'(hold_err), 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule